// File: doc/BRIEF.md
# Flow-Controlled Parallel-to-Serial Transmitter

This block takes a parallel word on a load request and sends it out one bit per clock on a single serial line, most significant bit first. A receiver-ready input acts as flow control. A word is accepted only while ready is high. If ready drops partway through a word, the line keeps the bit it is showing, and shifting continues from that same position once ready comes back.

A one-cycle frame marker goes high together with the first bit of each word. A busy flag covers the whole word. Load requests that arrive while busy is high are dropped. The line is low whenever the block is idle.

Top module: `ser_tx`

## Requirements
- R1: While rst_ni is low, ser_o, busy_o and frame_o are all 0.
- R2: When load_req_i and ready_i are both high at a clock edge while busy_o is low, the word is captured at that edge. In the following cycle busy_o=1 and ser_o=word_i[W-1].
- R3: A load request sampled while ready_i is low starts nothing: busy_o stays 0 and ser_o stays 0.
- R4: Each edge at which busy_o and ready_i are both high moves the line to the next lower bit of the captured word. Bit W-1-k is shown after k such edges.
- R5: An edge at which busy_o is high and ready_i is low leaves ser_o unchanged and the bit position unchanged. The next ready edge resumes with the following bit.
- R6: frame_o is high for exactly one cycle per word, in the cycle right after the capture edge, which is the cycle showing bit W-1. It is never high while busy_o is low.
- R7: busy_o falls at the W-th advancing edge. From then on ser_o is 0 until the next word is captured.
- R8: While busy_o is high, load_req_i and word_i have no effect on ser_o or on the word being sent.
- R9: The word width is the parameter W, with a default of 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_req_i | input | 1 | Request to capture word_i |
| word_i | input | W | Parallel word to send |
| ready_i | input | 1 | Receiver ready; low stalls or blocks a start |
| ser_o | output | 1 | Serial data, MSB first |
| frame_o | output | 1 | One-cycle marker on the first bit |
| busy_o | output | 1 | High while a word is in flight |

## Verification
Two functions can fall in the same cycle. The first case is the final advance of a word together with a load request that is still held high. The bench keeps load_req_i high, with an inverted word_i, through every word. The last shift must end with busy low and the line at 0, and nothing may start. The second case is a stall in the frame cycle itself. For every 4-bit word and every stall mask, the bench stalls before each selected bit. It then checks that the held bit matches, that frame drops after one cycle, and that the sequence resumes at the right bit.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;
  typedef enum logic [1:0] {
    CTL_HOLD  = 2'b00,
    CTL_LOAD  = 2'b01,
    CTL_SHIFT = 2'b10
  } ctl_e;
endpackage

// File: rtl/ser_tx_ctrl.sv
module ser_tx_ctrl
  import ser_tx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_req_i,
  input  logic ready_i,
  output ctl_e ctl_o,
  output logic busy_o,
  output logic frame_o
);
  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic          busy_q, frame_q;
  logic [CW-1:0] cnt_q;
  ctl_e          ctl;

  always_comb begin
    ctl = CTL_HOLD;
    if (!busy_q && load_req_i && ready_i) ctl = CTL_LOAD;
    else if (busy_q && ready_i)           ctl = CTL_SHIFT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      frame_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      frame_q <= 1'b0;
      unique case (ctl)
        CTL_LOAD: begin
          busy_q  <= 1'b1;
          frame_q <= 1'b1;
          cnt_q   <= '0;
        end
        CTL_SHIFT: begin
          if (cnt_q == LAST) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign ctl_o   = ctl;
  assign busy_o  = busy_q;
  assign frame_o = frame_q;

  p_start_needs_ready_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(ready_i) && $past(load_req_i));
  p_frame_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_q |=> !frame_q);
  p_frame_in_word_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_q |-> busy_q && cnt_q == '0);
  p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  p_stall_keeps_pos_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !ready_i |=> busy_q && $stable(cnt_q));
endmodule

// File: rtl/ser_tx_shreg.sv
module ser_tx_shreg
  import ser_tx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  ctl_e         ctl_i,
  input  logic [W-1:0] word_i,
  output logic         msb_o
);
  logic [W-1:0] q, d;

  // per-bit load/shift mux, zero shifted in at the bottom
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic below;
    if (i == 0) begin : g_lsb
      assign below = 1'b0;
    end else begin : g_up
      assign below = q[i-1];
    end
    always_comb begin
      unique case (ctl_i)
        CTL_LOAD:  d[i] = word_i[i];
        CTL_SHIFT: d[i] = below;
        default:   d[i] = q[i];
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= d;
  end

  assign msb_o = q[W-1];

  p_hold_bits_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i == CTL_HOLD |=> $stable(q));
endmodule

// File: rtl/ser_tx.sv
module ser_tx
  import ser_tx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_req_i,
  input  logic [W-1:0] word_i,
  input  logic         ready_i,
  output logic         ser_o,
  output logic         frame_o,
  output logic         busy_o
);
  ctl_e ctl;

  ser_tx_ctrl #(.W(W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_req_i (load_req_i),
    .ready_i    (ready_i),
    .ctl_o      (ctl),
    .busy_o     (busy_o),
    .frame_o    (frame_o)
  );

  ser_tx_shreg #(.W(W)) u_shreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ctl_i  (ctl),
    .word_i (word_i),
    .msb_o  (ser_o)
  );

  p_stall_holds_line_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !ready_i |=> $stable(ser_o));
  p_idle_line_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !ser_o);
  p_no_start_unready_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !ready_i |=> !busy_o);
  p_reset_quiet_r1: assert property (@(posedge clk_i)
    !rst_ni |-> !ser_o && !busy_o && !frame_o);
endmodule

// File: tb/ser_tx_bench.sv
module ser_tx_bench;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic load_req = 1'b0;
  logic [W-1:0] word = '0;
  logic ready = 1'b0;
  logic ser, frame, busy;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ser_tx #(.W(W)) u_ser_tx (
    .clk_i(clk), .rst_ni(rst_ni), .load_req_i(load_req), .word_i(word),
    .ready_i(ready), .ser_o(ser), .frame_o(frame), .busy_o(busy)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // send w; stall before bit k when mask[k] is set
  task automatic send(input logic [W-1:0] w, input logic [W-1:0] mask);
    word = w; load_req = 1'b1; ready = 1'b1;
    step();
    chk("R2 busy", busy, 1'b1);
    chk("R6 frame", frame, 1'b1);
    chk("R2 first bit", ser, w[W-1]);
    word = ~w;  // R8: held request with different word while busy
    for (int k = 0; k < W; k++) begin
      if (mask[k]) begin
        ready = 1'b0;
        step();
        chk("R5 held bit", ser, w[W-1-k]);
        chk("R5 busy", busy, 1'b1);
        chk("R6 frame gone", frame, 1'b0);
        ready = 1'b1;
      end
      step();
      if (k < W - 1) begin
        chk("R4 next bit", ser, w[W-2-k]);
        chk("R8 busy", busy, 1'b1);
        chk("R6 frame low", frame, 1'b0);
      end else begin
        chk("R7 busy drop", busy, 1'b0);
        chk("R7 line low", ser, 1'b0);
        chk("R6 frame idle", frame, 1'b0);
        load_req = 1'b0;
      end
    end
    step();
    chk("R8 no restart", busy, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ser", ser, 1'b0);
    chk("R1 busy", busy, 1'b0);
    chk("R1 frame", frame, 1'b0);
    rst_ni = 1'b1;
    // R3: request without ready
    word = '1; load_req = 1'b1; ready = 1'b0;
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R3 busy", busy, 1'b0);
      chk("R3 ser", ser, 1'b0);
    end
    load_req = 1'b0;
    step();
    // R9: width taken from parameter W; sweep all words and stall masks
    for (int w = 0; w < (1 << W); w++)
      for (int m = 0; m < (1 << W); m++)
        send(W'(w), W'(m));
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=running exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule